// File: doc/BRIEF.md
# Transmit Framer with Auto-Pad and Frame Check Sequence

This block stands between the transmit byte queue of an Ethernet-style MAC and its bit serialiser. For each frame it first generates the preamble and the start-of-frame delimiter. It then passes the host's frame bytes through unchanged. If asked, it pads a short frame with zero bytes up to the minimum body length. Last, it can append a 32-bit frame check sequence (FCS).

Two per-frame controls travel with the data: a "suppress FCS" bit and an "auto-pad" bit. Both are read at the single moment the byte flagged as end-of-frame is accepted. That copy then governs the rest of the frame. Auto-pad always forces an FCS, whatever the suppress bit says.

The output is a byte stream with a valid/ready handshake and a last-byte flag. The serialiser sends each byte least significant bit first.

Top module: `mtx_framer`

## Requirements
- R1: When a byte is offered in idle, the block first emits PRE_BYTES (default 7) bytes of 0x55 and then one 0xD5, without consuming the offered byte (in_ready stays 0 during this phase).
- R2: Frame bytes appear on the output unchanged and in order; a byte is consumed exactly when in_valid, in_ready and out_ready are all 1.
- R3: The FCS is 4 bytes of the CRC-32 computed LSB-first with the reflected polynomial 0xEDB88320 (generator 0x04C11DB7), preset to all ones, over all frame and pad bytes, then inverted. It is sent low byte first, so that LSB-first serialising puts the highest-order term on the wire first.
- R4: An FCS is appended if and only if, at acceptance of the end-of-frame byte, in_no_fcs is 0 or in_pad is 1. Otherwise the block goes idle right after that byte.
- R5: With in_pad = 1, bytes of 0x00 follow the data until data plus pad equals MIN_BODY (default 60) bytes. A frame already at or above MIN_BODY gets no pad.
- R6: With in_pad = 0, no pad byte is added, even for a frame shorter than MIN_BODY.
- R7: Changes to in_no_fcs and in_pad after the end-of-frame byte has been accepted have no effect on that frame.
- R8: out_last is 1 on exactly one byte per frame: the last FCS byte, or the end-of-frame data byte when no FCS follows.
- R9: While out_valid is 1 and out_ready is 0, a generated byte (preamble, pad or FCS) stays on out_data with out_valid held.
- R10: During reset, out_valid and in_ready are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte offered |
| in_data | input | 8 | Frame byte |
| in_eof | input | 1 | Offered byte is the last of its frame |
| in_no_fcs | input | 1 | Suppress FCS, read with the end-of-frame byte |
| in_pad | input | 1 | Auto-pad, read with the end-of-frame byte |
| in_ready | output | 1 | Frame byte accepted this cycle when valid |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| out_ready | input | 1 | Serialiser takes the output byte |

## Verification
On every cycle, the assertions check these relations:
- the CRC register is seeded while the preamble goes out;
- the byte count reaches the minimum before the FCS of a padded frame;
- the latched controls stay frozen through the pad and FCS phases;
- a frame without FCS ends the cycle after its last byte;
- out_last never appears without out_valid;
- generated bytes hold under back-pressure.

Only the bench's scenarios can show the rest. These are the exact byte values of the preamble, data, pad and FCS, and the pad count for lengths just below, at and above the minimum. They also include the choice of FCS for every combination of the two controls, and the fact that flipping the controls after the end-of-frame byte changes nothing.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_DATA,
      ST_PAD,
      ST_FCS
   } mtx_state_e;

   localparam logic [7:0]  PRE_OCTET    = 8'h55;
   localparam logic [7:0]  SFD_OCTET    = 8'hD5;
   localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;
   localparam int          FCS_BYTES    = 4;
endpackage

// File: rtl/mtx_crc_unit.sv
module mtx_crc_unit #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seed,
   input  logic          step,
   input  logic [DW-1:0] din,
   output logic [31:0]   crc_q
);
   import mtx_pkg::*;

   logic [31:0] chain [0:DW];

   assign chain[0] = crc_q;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      logic fb;
      assign fb          = chain[b][0] ^ din[b];
      assign chain[b+1]  = (chain[b] >> 1) ^ (fb ? CRC_POLY_REV : 32'h0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || seed) crc_q <= CRC_SEED;
      else if (step)      crc_q <= chain[DW];
   end
endmodule

// File: rtl/mtx_len_ctr.sv
module mtx_len_ctr #(
   parameter int MAXV = 60,
   localparam int W = $clog2(MAXV + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr)                      cnt_q <= '0;
      else if (inc && cnt_q != W'(MAXV))      cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/mtx_framer.sv
module mtx_framer #(
   parameter int          PRE_BYTES = 7,
   parameter int          MIN_BODY  = 60,
   parameter logic [7:0]  PAD_VALUE = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_eof,
   input  logic       in_no_fcs,
   input  logic       in_pad,
   output logic       in_ready,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_last,
   input  logic       out_ready
);
   import mtx_pkg::*;

   localparam int POS_MAX = (PRE_BYTES > FCS_BYTES) ? PRE_BYTES : FCS_BYTES;
   localparam int POS_W   = $clog2(POS_MAX + 1);
   localparam int LEN_W   = $clog2(MIN_BODY + 1);

   if (PRE_BYTES < 1) begin : g_bad_pre
      $error("PRE_BYTES must be at least 1");
   end
   if (MIN_BODY < 2) begin : g_bad_min
      $error("MIN_BODY must be at least 2");
   end

   mtx_state_e       st_q, st_d;
   logic [POS_W-1:0] pos_q;
   logic             fcs_on_q, pad_on_q;
   logic             ctl_load;
   logic             crc_step;
   logic [7:0]       crc_din;
   logic [31:0]      crc_q, crc_inv;
   logic             len_inc;
   logic [LEN_W-1:0] len_q;
   logic             out_fire, in_fire;

   assign out_fire = out_valid & out_ready;
   assign in_fire  = in_valid & in_ready;
   assign crc_inv  = ~crc_q;

   mtx_crc_unit #(.DW(8)) i_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (st_q == ST_IDLE),
      .step  (crc_step),
      .din   (crc_din),
      .crc_q (crc_q)
   );

   mtx_len_ctr #(.MAXV(MIN_BODY)) i_len (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q == ST_IDLE),
      .inc   (len_inc),
      .cnt_q (len_q)
   );

   always_comb begin
      st_d      = st_q;
      out_valid = 1'b0;
      out_data  = PAD_VALUE;
      out_last  = 1'b0;
      in_ready  = 1'b0;
      crc_step  = 1'b0;
      crc_din   = in_data;
      len_inc   = 1'b0;
      ctl_load  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (in_valid) st_d = ST_PRE;
         end
         ST_PRE: begin
            out_valid = 1'b1;
            out_data  = (pos_q == POS_W'(PRE_BYTES)) ? SFD_OCTET : PRE_OCTET;
            if (out_ready && pos_q == POS_W'(PRE_BYTES)) st_d = ST_DATA;
         end
         ST_DATA: begin
            out_valid = in_valid;
            out_data  = in_data;
            in_ready  = out_ready;
            out_last  = in_eof & in_no_fcs & ~in_pad;
            if (in_fire) begin
               crc_step = 1'b1;
               len_inc  = 1'b1;
               if (in_eof) begin
                  ctl_load = 1'b1;
                  if (in_pad && len_q < LEN_W'(MIN_BODY - 1)) st_d = ST_PAD;
                  else if (!in_no_fcs || in_pad)              st_d = ST_FCS;
                  else                                        st_d = ST_IDLE;
               end
            end
         end
         ST_PAD: begin
            out_valid = 1'b1;
            crc_din   = PAD_VALUE;
            crc_step  = out_ready;
            len_inc   = out_ready;
            out_last  = !fcs_on_q && len_q == LEN_W'(MIN_BODY - 1);
            if (out_ready && len_q == LEN_W'(MIN_BODY - 1))
               st_d = fcs_on_q ? ST_FCS : ST_IDLE;
         end
         ST_FCS: begin
            out_valid = 1'b1;
            out_data  = 8'(crc_inv >> (8 * pos_q));
            out_last  = (pos_q == POS_W'(FCS_BYTES - 1));
            if (out_ready && pos_q == POS_W'(FCS_BYTES - 1)) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pos_q    <= '0;
         fcs_on_q <= 1'b1;
         pad_on_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d != st_q)
            pos_q <= '0;
         else if (out_fire && (st_q == ST_PRE || st_q == ST_FCS))
            pos_q <= pos_q + 1'b1;
         if (ctl_load) begin
            fcs_on_q <= ~in_no_fcs | in_pad;
            pad_on_q <= in_pad;
         end
      end
   end

   assert_pre_crc_seeded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PRE) |-> (crc_q == CRC_SEED));

   assert_pad_min_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FCS && pad_on_q) |-> (len_q == LEN_W'(MIN_BODY)));

   assert_ctl_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_PAD || st_q == ST_FCS) && (st_d == ST_PAD || st_d == ST_FCS))
      |=> ($stable(fcs_on_q) && $stable(pad_on_q)));

   assert_no_fcs_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && in_valid && out_ready && in_eof && in_no_fcs && !in_pad)
      |=> !out_valid);

   assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && st_q != ST_DATA && st_q != ST_IDLE)
      |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/test_mtx_framer.sv
module test_mtx_framer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_eof = 1'b0;
   logic       in_no_fcs = 1'b0;
   logic       in_pad = 1'b0;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_last;
   logic       out_ready = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int stall_mode = 0;
   logic [7:0] lfsr = 8'hA5;

   logic [7:0] exp_d[$];
   logic       exp_l[$];
   string      exp_r[$];

   always #10 clk = ~clk;

   mtx_framer i_mtx_framer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_eof(in_eof), .in_no_fcs(in_no_fcs), .in_pad(in_pad),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .out_ready(out_ready)
   );

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= (stall_mode == 0) ? 1'b1 : lfsr[0] | lfsr[3];
   end

   function automatic logic [31:0] crc_ref(logic [7:0] b[$]);
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (b[i]) begin
         for (int k = 0; k < 8; k++) begin
            if ((c[0] ^ b[i][k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
            else                          c = c >> 1;
         end
      end
      return ~c;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      #2;
      if (rst_n && out_valid && out_ready) begin
         if (exp_d.size() == 0) begin
            check(1'b0, "R8", "unexpected output byte", out_data, 0);
         end else begin
            check(out_data == exp_d[0], exp_r[0], "byte", out_data, exp_d[0]);
            check(out_last == exp_l[0], "R8", "last flag", out_last, exp_l[0]);
            void'(exp_d.pop_front());
            void'(exp_l.pop_front());
            void'(exp_r.pop_front());
         end
      end
      if (rst_n && out_valid && !out_ready) begin
         check(in_ready == 1'b0, "R2", "in_ready while stalled", in_ready, 0);
      end
   end

   task automatic push(logic [7:0] d, logic l, string r);
      exp_d.push_back(d);
      exp_l.push_back(l);
      exp_r.push_back(r);
   endtask

   task automatic send_frame(int n, bit pad, bit nofcs, int seed);
      logic [7:0] body[$];
      bit fcs_on;
      int npad;
      logic [31:0] f;
      fcs_on = !nofcs || pad;
      for (int i = 0; i < n; i++) body.push_back(8'(seed + i * 7));
      npad = (pad && n < 60) ? 60 - n : 0;
      for (int i = 0; i < 7; i++) push(8'h55, 1'b0, "R1");
      push(8'hD5, 1'b0, "R1");
      for (int i = 0; i < n; i++)
         push(body[i], (i == n - 1) && !fcs_on, "R2");
      for (int i = 0; i < npad; i++) begin
         push(8'h00, 1'b0, pad ? "R5" : "R6");
         body.push_back(8'h00);
      end
      if (fcs_on) begin
         f = crc_ref(body);
         for (int i = 0; i < 4; i++) push(8'(f >> (8 * i)), i == 3, "R3");
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_data   = 8'(seed + i * 7);
         in_eof    = (i == n - 1);
         in_no_fcs = (i == n - 1) ? nofcs : ~nofcs;
         in_pad    = (i == n - 1) ? pad : ~pad;
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
         end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid  = 1'b0;
      in_eof    = 1'b0;
      in_no_fcs = ~nofcs;
      in_pad    = ~pad;
      while (exp_d.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R4", "idle after frame", out_valid, 0);
   endtask

   initial begin
      logic [7:0] ascii[$];
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      in_valid = 1'b1;
      #1;
      check(in_ready == 1'b0, "R10", "in_ready in reset", in_ready, 0);
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < 9; i++) ascii.push_back(8'h31 + 8'(i));
      check(crc_ref(ascii) == 32'hCBF43926, "R3", "reference CRC", crc_ref(ascii), 32'hCBF43926);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
      send_frame(10, 1'b1, 1'b1, 3);    // R5 R4: pad forces FCS
      send_frame(10, 1'b0, 1'b1, 17);   // R6 R4: no pad, no FCS
      send_frame(20, 1'b0, 1'b0, 40);   // R3: FCS, no pad
      stall_mode = 1;
      send_frame(59, 1'b1, 1'b0, 5);    // R5: one pad byte, R9 stalls
      send_frame(60, 1'b1, 1'b1, 9);    // R5: exactly minimum
      send_frame(70, 1'b1, 1'b1, 11);   // R5: above minimum
      send_frame(1, 1'b0, 1'b0, 77);    // R7: single byte, controls flipped after
      send_frame(3, 1'b0, 1'b1, 90);    // R7 R8
      stall_mode = 0;
      send_frame(61, 1'b0, 1'b0, 123);
      check(exp_d.size() == 0, "R8", "queue drained", exp_d.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule